// File: doc/BRIEF.md
# Pipelined Synchronous Burst SRAM

This block is a synthesizable model of a synchronous static RAM with a burst engine and a pipelined read path. Every control, address and data input is sampled on the rising clock edge. A new external address, together with the chip-select state, enters the block only when one of two active-low address strobes is low. One strobe is for a CPU and one is for a memory controller. After that, a 2-bit burst counter supplies the low two address bits for later accesses. The counter steps only while the advance input is low. When neither a strobe nor advance is present, the current location is accessed again.

Writes work on byte lanes. Each lane has an active-low enable, and those enables are honoured only while a shared byte-write gate is low. A global write input overrides all of them and writes every lane. The CPU strobe always starts a read. Read data passes through a capture stage and then an output register. Output enable acts combinationally on the data pins.

Selection is tracked by a two-state machine. `ST_IDLE` means deselected and `ST_ACTIVE` means selected, with a burst address held. It has three transitions, each taken when a strobe is seen:
- `T_SELECT` moves to `ST_ACTIVE` when all three chip selects are active.
- `T_DESELECT` moves to `ST_IDLE` when any chip select is inactive.
- `T_STAY` keeps the current state when no strobe is present.

Top module: `sync_burst_sram`

## Requirements
- R1: After reset, the block is in `ST_IDLE`, `dout` is 0 and `dout_drive` is 0. Cycles with no strobe perform no access.
- R2: `addr` and the three chip selects are used only in a cycle where `strobe_cpu_n` or `strobe_ctl_n` is 0. In other cycles `addr` has no effect.
- R3: The block is selected only when `sel_a_n`=0, `sel_b`=1 and `sel_c_n`=0. A strobe with any other combination deselects it. While deselected, no read data is driven and no write reaches the array.
- R4: A read whose command is sampled at edge k drives its word on `dout`, with `dout_drive`=1, after edge k+1.
- R5: In a cycle with `strobe_cpu_n`=0, the access is a read and all write controls are ignored.
- R6: A write happens in a `strobe_ctl_n` cycle, or in a later advance or hold cycle, when the write controls are active. The written word is available to the next read cycle.
- R7: With `byte_gate_n`=0 and `all_we_n`=1, lane i (bits 8i+7:8i) is written exactly when `byte_we_n[i]`=0, and the other lanes keep their contents. With `byte_gate_n`=1 and `all_we_n`=1 the access is a read.
- R8: `all_we_n`=0 writes all four lanes whatever the values of `byte_we_n` and `byte_gate_n`.
- R9: With `xor_order`=0, each no-strobe cycle with `advance_n`=0 increments the burst count. The low two address bits are then (start + count) mod 4, so the burst wraps inside its aligned group of four, and the upper bits stay at the start address.
- R10: With `xor_order`=1, the low two address bits are start XOR count.
- R11: A cycle with no strobe and `advance_n`=1 accesses the same address as the previous cycle.
- R12: `oe_n`=1 forces `dout`=0 and `dout_drive`=0 at once, within the cycle. The pipeline keeps its contents, so the data reappears when `oe_n` returns to 0.
- R13: When both strobes are 0 together, the CPU strobe wins and the access is a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr | input | ADDR_W | External word address |
| wdata | input | LANES*LANE_W | Write data |
| sel_a_n | input | 1 | Active-low pipelining chip select |
| sel_b | input | 1 | Active-high depth-expansion select |
| sel_c_n | input | 1 | Active-low depth-expansion select |
| strobe_cpu_n | input | 1 | Active-low CPU address strobe (always a read) |
| strobe_ctl_n | input | 1 | Active-low controller address strobe |
| advance_n | input | 1 | Active-low burst advance |
| byte_we_n | input | LANES | Active-low per-lane write enables |
| byte_gate_n | input | 1 | Active-low gate for the lane enables |
| all_we_n | input | 1 | Active-low global write |
| xor_order | input | 1 | Burst order: 0 linear, 1 XOR |
| oe_n | input | 1 | Active-low asynchronous output enable |
| dout | output | LANES*LANE_W | Read data, 0 when not driven |
| dout_drive | output | 1 | High while `dout` carries valid data |

## Verification
The interaction most likely to fail is a write committing in the same edge at which a read of the same word is captured. A byte-masked write to a word is followed directly by a CPU read of that word. The returned value must hold the new lanes merged with the old ones. A second case is a held burst cycle whose masked write lands on the word that the previous cycle wrote. That word is read back on the next cycle and judged against a reference array in the bench.

// File: rtl/sbsram_pkg.sv
package sbsram_pkg;

    // Selection state of the device
    typedef enum logic {
        ST_IDLE   = 1'b0,
        ST_ACTIVE = 1'b1
    } sel_state_t;

    // Low address bits for a burst position
    function automatic logic [1:0] burst_low(
        input logic [1:0] start,
        input logic [1:0] count,
        input logic       xor_mode
    );
        logic [1:0] r;
        if (xor_mode) r = start ^ count;
        else          r = start + count;
        return r;
    endfunction

endpackage

// File: rtl/sbsram_burst_ctr.sv
module sbsram_burst_ctr
    import sbsram_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              step,
    input  logic              xor_order,
    input  logic [ADDR_W-1:0] load_addr,
    output logic [ADDR_W-1:0] cur_addr
);
    localparam int HI_W = ADDR_W - 2;

    logic [ADDR_W-1:0] base_q;
    logic [1:0]        cnt_q;
    logic [1:0]        cnt_use;

    assign cnt_use  = step ? (cnt_q + 2'd1) : cnt_q;
    assign cur_addr = load ? load_addr
                           : {base_q[ADDR_W-1 -: HI_W], burst_low(base_q[1:0], cnt_use, xor_order)};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            base_q <= '0;
            cnt_q  <= 2'd0;
        end else if (load) begin
            base_q <= load_addr;
            cnt_q  <= 2'd0;
        end else if (step) begin
            cnt_q  <= cnt_q + 2'd1;
        end
    end

    AST_GROUP_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !load) |=> (load || (cur_addr[ADDR_W-1:2] == $past(cur_addr[ADDR_W-1:2])))); // R9

    AST_HOLD_SAME: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !step) |=> (load || step || !$stable(xor_order) || $stable(cur_addr))); // R11

endmodule

// File: rtl/sbsram_wmask.sv
module sbsram_wmask #(
    parameter int LANES = 4
) (
    input  logic             all_we_n,
    input  logic             byte_gate_n,
    input  logic [LANES-1:0] byte_we_n,
    input  logic             block,
    output logic [LANES-1:0] lane_mask
);
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign lane_mask[g] = !block && (!all_we_n || (!byte_gate_n && !byte_we_n[g]));
    end
endmodule

// File: rtl/sbsram_array.sv
module sbsram_array #(
    parameter int ADDR_W = 6,
    parameter int LANES  = 4,
    parameter int LANE_W = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_en,
    input  logic                    rd_en,
    input  logic [ADDR_W-1:0]       addr,
    input  logic [LANES-1:0]        lane_mask,
    input  logic [LANES*LANE_W-1:0] wdata,
    output logic [LANES*LANE_W-1:0] q,
    output logic                    q_valid
);
    localparam int DEPTH = 1 << ADDR_W;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [LANE_W-1:0] lane_mem [DEPTH];
        logic [LANE_W-1:0] lane_q;

        always_ff @(posedge clk) begin
            if (wr_en && lane_mask[g])
                lane_mem[addr] <= wdata[g*LANE_W +: LANE_W];
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)     lane_q <= '0;
            else if (rd_en) lane_q <= lane_mem[addr];
        end

        assign q[g*LANE_W +: LANE_W] = lane_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q_valid <= 1'b0;
        else        q_valid <= rd_en;
    end

    AST_NO_RD_WR_MIX: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_en && wr_en)); // R7

endmodule

// File: rtl/sync_burst_sram.sv
module sync_burst_sram
    import sbsram_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int LANES  = 4,
    parameter int LANE_W = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [ADDR_W-1:0]       addr,
    input  logic [LANES*LANE_W-1:0] wdata,
    input  logic                    sel_a_n,
    input  logic                    sel_b,
    input  logic                    sel_c_n,
    input  logic                    strobe_cpu_n,
    input  logic                    strobe_ctl_n,
    input  logic                    advance_n,
    input  logic [LANES-1:0]        byte_we_n,
    input  logic                    byte_gate_n,
    input  logic                    all_we_n,
    input  logic                    xor_order,
    input  logic                    oe_n,
    output logic [LANES*LANE_W-1:0] dout,
    output logic                    dout_drive
);
    localparam int DW = LANES * LANE_W;

    sel_state_t st_q, st_d;

    logic              cpu_cyc, strobe, all_en, step, access;
    logic [ADDR_W-1:0] cur_addr;
    logic [LANES-1:0]  mask;

    // capture stage
    logic              wr_q, rd_q;
    logic [ADDR_W-1:0] addr_q;
    logic [LANES-1:0]  mask_q;
    logic [DW-1:0]     wdata_q;

    logic [DW-1:0]     q;
    logic              q_valid;

    assign cpu_cyc = !strobe_cpu_n;
    assign strobe  = cpu_cyc || !strobe_ctl_n;
    assign all_en  = !sel_a_n && sel_b && !sel_c_n;
    assign step    = !strobe && !advance_n && (st_q == ST_ACTIVE);

    sbsram_burst_ctr #(.ADDR_W(ADDR_W)) u_ctr (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (strobe),
        .step      (step),
        .xor_order (xor_order),
        .load_addr (addr),
        .cur_addr  (cur_addr)
    );

    sbsram_wmask #(.LANES(LANES)) u_mask (
        .all_we_n    (all_we_n),
        .byte_gate_n (byte_gate_n),
        .byte_we_n   (byte_we_n),
        .block       (cpu_cyc),
        .lane_mask   (mask)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
    end

    // next state and access decision
    always_comb begin
        st_d   = st_q;
        access = 1'b0;
        unique case (st_q)
            ST_IDLE: begin
                if (strobe) begin
                    access = all_en;
                    st_d   = all_en ? ST_ACTIVE : ST_IDLE;
                end
            end
            ST_ACTIVE: begin
                if (strobe) begin
                    access = all_en;
                    st_d   = all_en ? ST_ACTIVE : ST_IDLE;
                end else begin
                    access = 1'b1;
                end
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_q    <= 1'b0;
            rd_q    <= 1'b0;
            addr_q  <= '0;
            mask_q  <= '0;
            wdata_q <= '0;
        end else begin
            wr_q    <= access && (mask != '0);
            rd_q    <= access && (mask == '0);
            addr_q  <= cur_addr;
            mask_q  <= mask;
            wdata_q <= wdata;
        end
    end

    sbsram_array #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_array (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_q),
        .rd_en     (rd_q),
        .addr      (addr_q),
        .lane_mask (mask_q),
        .wdata     (wdata_q),
        .q         (q),
        .q_valid   (q_valid)
    );

    assign dout_drive = !oe_n && q_valid;
    assign dout       = dout_drive ? q : '0;

    AST_DESEL_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe && !all_en) |=> (!wr_q && !rd_q)); // R3

    AST_CPU_READS: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_cyc && all_en) |=> (rd_q && !wr_q)); // R5

    AST_GLOBAL_ALL: assert property (@(posedge clk) disable iff (!rst_n)
        (!all_we_n && !cpu_cyc && access) |=> (wr_q && (mask_q == '1))); // R8

    AST_READ_LAT: assert property (@(posedge clk) disable iff (!rst_n)
        (access && (mask == '0)) |-> ##2 q_valid); // R4

endmodule

// File: tb/tb_sync_burst_sram.sv
module tb_sync_burst_sram;
    localparam int CLK_P = 10;
    localparam int S_NO = 0, S_PR = 1, S_CT = 2, S_BO = 3;
    localparam int C_ON = 0, C_1 = 1, C_2 = 2, C_3 = 3;
    localparam int W_NO = 0, W_BY = 1, W_GL = 2;

    typedef struct packed {
        logic [3:0]  req;
        logic [1:0]  strb;
        logic [1:0]  ce;
        logic [1:0]  wc;
        logic [3:0]  bw;
        logic        adv;
        logic        mode;
        logic        oe;
        logic [5:0]  addr;
        logic [31:0] data;
    } vec_t;

    function automatic vec_t mk(int req, int strb, int ce, int wc, logic [3:0] bw,
                                logic adv, logic mode, logic oe, logic [5:0] a, logic [31:0] d);
        vec_t v;
        v.req = req[3:0]; v.strb = strb[1:0]; v.ce = ce[1:0]; v.wc = wc[1:0];
        v.bw = bw; v.adv = adv; v.mode = mode; v.oe = oe; v.addr = a; v.data = d;
        return v;
    endfunction

    localparam int NV = 39;
    localparam vec_t VECS [NV] = '{
        mk(1,  S_NO, C_ON, W_GL, 4'hF, 0, 0, 0, 6'h00, 32'hDEADBEEF), // R1 no access after reset
        mk(1,  S_NO, C_ON, W_GL, 4'hF, 0, 0, 0, 6'h00, 32'hDEADBEEF),
        mk(8,  S_CT, C_ON, W_GL, 4'hF, 1, 0, 0, 6'h10, 32'hA0A0A0A0), // R8 override
        mk(9,  S_NO, C_ON, W_GL, 4'hF, 0, 0, 0, 6'h3F, 32'hA1A1A1A1), // R9
        mk(9,  S_NO, C_ON, W_GL, 4'hF, 0, 0, 0, 6'h3F, 32'hA2A2A2A2),
        mk(9,  S_NO, C_ON, W_GL, 4'hF, 0, 0, 0, 6'h3F, 32'hA3A3A3A3),
        mk(4,  S_PR, C_ON, W_NO, 4'hF, 1, 0, 0, 6'h12, 32'h0),        // R4
        mk(9,  S_NO, C_ON, W_NO, 4'hF, 0, 0, 0, 6'h3F, 32'h0),
        mk(9,  S_NO, C_ON, W_NO, 4'hF, 0, 0, 0, 6'h3F, 32'h0),        // wrap
        mk(2,  S_NO, C_ON, W_NO, 4'hF, 1, 0, 0, 6'h3F, 32'h0),        // R2 addr ignored
        mk(9,  S_NO, C_ON, W_NO, 4'hF, 0, 0, 0, 6'h3F, 32'h0),
        mk(10, S_PR, C_ON, W_NO, 4'hF, 1, 1, 0, 6'h13, 32'h0),        // R10
        mk(10, S_NO, C_ON, W_NO, 4'hF, 0, 1, 0, 6'h00, 32'h0),
        mk(10, S_NO, C_ON, W_NO, 4'hF, 0, 1, 0, 6'h00, 32'h0),
        mk(10, S_NO, C_ON, W_NO, 4'hF, 0, 1, 0, 6'h00, 32'h0),
        mk(7,  S_CT, C_ON, W_BY, 4'b1010, 1, 0, 0, 6'h11, 32'h55665577), // R7
        mk(7,  S_PR, C_ON, W_NO, 4'hF, 1, 0, 0, 6'h11, 32'h0),
        mk(5,  S_PR, C_ON, W_GL, 4'h0, 1, 0, 0, 6'h12, 32'hFFFFFFFF), // R5
        mk(5,  S_PR, C_ON, W_NO, 4'hF, 1, 0, 0, 6'h12, 32'h0),
        mk(13, S_BO, C_ON, W_GL, 4'h0, 1, 0, 0, 6'h13, 32'h0),        // R13
        mk(13, S_PR, C_ON, W_NO, 4'hF, 1, 0, 0, 6'h13, 32'h0),
        mk(3,  S_CT, C_1,  W_GL, 4'hF, 1, 0, 0, 6'h10, 32'h0),        // R3
        mk(3,  S_NO, C_ON, W_GL, 4'hF, 0, 0, 0, 6'h10, 32'h0),
        mk(3,  S_PR, C_ON, W_NO, 4'hF, 1, 0, 0, 6'h10, 32'h0),
        mk(3,  S_CT, C_2,  W_GL, 4'hF, 1, 0, 0, 6'h10, 32'h0),
        mk(3,  S_PR, C_2,  W_NO, 4'hF, 1, 0, 0, 6'h10, 32'h0),
        mk(3,  S_PR, C_3,  W_NO, 4'hF, 1, 0, 0, 6'h10, 32'h0),
        mk(3,  S_PR, C_ON, W_NO, 4'hF, 1, 0, 0, 6'h10, 32'h0),
        mk(7,  S_CT, C_ON, W_NO, 4'h0, 1, 0, 0, 6'h12, 32'h0),        // R7 gate off: read
        mk(6,  S_CT, C_ON, W_GL, 4'hF, 1, 0, 0, 6'h20, 32'h12345678), // R6
        mk(6,  S_NO, C_ON, W_GL, 4'hF, 0, 0, 0, 6'h00, 32'h9ABCDEF0),
        mk(6,  S_CT, C_ON, W_BY, 4'b1110, 1, 0, 0, 6'h21, 32'h000000AB),
        mk(11, S_NO, C_ON, W_BY, 4'b0111, 1, 0, 0, 6'h00, 32'hCD000000), // R11
        mk(6,  S_PR, C_ON, W_NO, 4'hF, 1, 0, 0, 6'h21, 32'h0),
        mk(4,  S_PR, C_ON, W_NO, 4'hF, 1, 0, 0, 6'h20, 32'h0),
        mk(12, S_NO, C_ON, W_NO, 4'hF, 1, 0, 1, 6'h00, 32'h0),        // R12
        mk(12, S_PR, C_ON, W_NO, 4'hF, 1, 0, 0, 6'h20, 32'h0),
        mk(12, S_CT, C_1,  W_NO, 4'hF, 1, 0, 0, 6'h00, 32'h0),
        mk(3,  S_CT, C_1,  W_NO, 4'hF, 1, 0, 0, 6'h00, 32'h0)
    };

    logic        clk = 1'b0;
    logic        rst_n;
    logic [5:0]  addr;
    logic [31:0] wdata;
    logic        sel_a_n, sel_b, sel_c_n, strobe_cpu_n, strobe_ctl_n, advance_n;
    logic [3:0]  byte_we_n;
    logic        byte_gate_n, all_we_n, xor_order, oe_n;
    logic [31:0] dout;
    logic        dout_drive;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    logic [31:0] ref_mem [64];
    logic        r_sel;
    logic [5:0]  r_base;
    logic [1:0]  r_cnt;

    always #(CLK_P/2) clk = ~clk;

    sync_burst_sram dut (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata),
        .sel_a_n(sel_a_n), .sel_b(sel_b), .sel_c_n(sel_c_n),
        .strobe_cpu_n(strobe_cpu_n), .strobe_ctl_n(strobe_ctl_n), .advance_n(advance_n),
        .byte_we_n(byte_we_n), .byte_gate_n(byte_gate_n), .all_we_n(all_we_n),
        .xor_order(xor_order), .oe_n(oe_n), .dout(dout), .dout_drive(dout_drive)
    );

    function automatic string rtag(logic [3:0] r);
        case (r)
            4'd1:  return "R1";
            4'd2:  return "R2";
            4'd3:  return "R3";
            4'd4:  return "R4";
            4'd5:  return "R5";
            4'd6:  return "R6";
            4'd7:  return "R7";
            4'd8:  return "R8";
            4'd9:  return "R9";
            4'd10: return "R10";
            4'd11: return "R11";
            4'd12: return "R12";
            4'd13: return "R13";
            default: return "R?";
        endcase
    endfunction

    task automatic chk(bit ok, string tag, logic [32:0] act, logic [32:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual drive/data=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic drive(vec_t v);
        strobe_cpu_n = !v.strb[0];
        strobe_ctl_n = !v.strb[1];
        sel_a_n      = (v.ce == 2'd1);
        sel_b        = (v.ce != 2'd2);
        sel_c_n      = (v.ce == 2'd3);
        all_we_n     = (v.wc != 2'd2);
        byte_gate_n  = (v.wc != 2'd1);
        byte_we_n    = v.bw;
        advance_n    = v.adv;
        xor_order    = v.mode;
        oe_n         = v.oe;
        addr         = v.addr;
        wdata        = v.data;
    endtask

    // reference model built from the requirements
    task automatic model(vec_t v, output logic vld, output logic [31:0] dat);
        logic       acc;
        logic [3:0] m;
        logic [5:0] a;
        logic [1:0] lo;
        if (v.strb[0])          m = 4'h0;
        else if (v.wc == 2'd2)  m = 4'hF;
        else if (v.wc == 2'd1)  m = ~v.bw;
        else                    m = 4'h0;
        if (v.strb != 2'd0) begin
            acc = (v.ce == 2'd0);
            r_sel = acc; r_base = v.addr; r_cnt = 2'd0;
            a = v.addr;
        end else begin
            acc = r_sel;
            if (r_sel && !v.adv) r_cnt = r_cnt + 2'd1;
            lo = v.mode ? (r_base[1:0] ^ r_cnt) : (r_base[1:0] + r_cnt);
            a = {r_base[5:2], lo};
        end
        vld = acc && (m == 4'h0);
        dat = ref_mem[a];
        if (acc && m != 4'h0)
            for (int b = 0; b < 4; b++)
                if (m[b]) ref_mem[a][b*8 +: 8] = v.data[b*8 +: 8];
    endtask

    initial begin
        #(CLK_P * 150000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        logic        e1v, e2v, cv;
        logic [31:0] e1d, e2d, cd;
        logic [3:0]  e1r, e2r;
        logic        xd;
        rst_n = 1'b0;
        r_sel = 1'b0; r_base = '0; r_cnt = '0;
        drive(mk(1, S_NO, C_ON, W_NO, 4'hF, 1, 0, 0, 6'h00, 32'h0));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        chk(dout_drive == 1'b0 && dout == 32'h0, "R1", {dout_drive, dout}, 33'h0);

        e1v = 0; e2v = 0; e1d = '0; e2d = '0; e1r = 4'd1; e2r = 4'd1;
        for (int i = 0; i < NV + 2; i++) begin
            if (i > 0) @(negedge clk);
            if (i >= 2) begin
                xd = e2v && !oe_n;
                chk((dout_drive == xd) && (dout == (xd ? e2d : 32'h0)), rtag(e2r),
                    {dout_drive, dout}, {xd, xd ? e2d : 32'h0});
            end
            e2v = e1v; e2d = e1d; e2r = e1r;
            if (i < NV) begin
                drive(VECS[i]);
                model(VECS[i], cv, cd);
                e1v = cv; e1d = cd; e1r = VECS[i].req;
            end else begin
                drive(VECS[NV-1]);
                model(VECS[NV-1], cv, cd);
                e1v = cv; e1d = cd; e1r = 4'd3;
            end
            @(posedge clk);
        end

        // asynchronous output enable inside one cycle (R12)
        @(negedge clk);
        drive(mk(12, S_PR, C_ON, W_NO, 4'hF, 1, 0, 0, 6'h10, 32'h0));
        @(negedge clk);
        drive(mk(12, S_CT, C_1, W_NO, 4'hF, 1, 0, 0, 6'h00, 32'h0));
        @(negedge clk);
        chk(dout_drive && dout == 32'hA0A0A0A0, "R12", {dout_drive, dout}, {1'b1, 32'hA0A0A0A0});
        oe_n = 1'b1;
        #1;
        chk(!dout_drive && dout == 32'h0, "R12", {dout_drive, dout}, 33'h0);
        oe_n = 1'b0;
        #1;
        chk(dout_drive && dout == 32'hA0A0A0A0, "R12", {dout_drive, dout}, {1'b1, 32'hA0A0A0A0});

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule